// File: doc/BRIEF.md
# Toggle-Bit Status Polling Controller

This block lets a host wait for a flash device to finish a program or erase operation. A single-cycle `start` latches the address to poll. The block then issues byte reads on a request/acknowledge read port and compares the selected toggle bit across each pair of reads. It also watches the timeout flag, and reports the outcome as a one-cycle `done` or `fail` pulse.

A flag seen high is not taken as failure right away, because the operation may have completed at the moment the flag rose. The block first takes one more pair of confirmation reads. It reports failure only if the toggle bit is still moving in that pair. On failure it writes the device's reset command over a separate write port and waits for that write to be acknowledged before it pulses `fail`.

An optional watchdog counts toggling read pairs and forces the failure path when its limit is reached. An `abort` input abandons polling. The next `start` then begins again from the first read of a fresh pair.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset, `busy`, `rd_req`, `wr_req`, `done` and `fail` are all low.
- R2: A `start` accepted while idle raises `rd_req` in the next cycle with `rd_addr` equal to the `poll_addr` latched at start. Each request stays high with a stable address until `rd_ack` is seen.
- R3: Reads are taken in pairs. The toggle bit from the first read is stored and compared with the second. If the bit is equal, `done` pulses in the cycle after the second acknowledge.
- R4: If the toggle bit differs within a pair and the timeout flag (bit 5 of the second read) is 0, another pair of reads follows, and neither `done` nor `fail` pulses.
- R5: If the toggle bit differs within a pair and the timeout flag is 1, two confirmation reads follow. If the toggle bit is equal across them, `done` pulses.
- R6: If the confirmation pair still toggles, a single write of data 0xF0 to the polled address is requested. `wr_req` is held until `wr_ack`, and `fail` pulses in the cycle after `wr_ack`.
- R7: When `sel_dq2` is 0 the toggle bit is bit 6. When it is 1 the toggle bit is bit 2. The unselected bit has no effect on the outcome.
- R8: With `MAX_PAIRS` greater than 0, the `MAX_PAIRS`-th consecutive pair that toggles with the flag low takes the failure path of R6. A value of 0 disables the watchdog.
- R9: `done` and `fail` last exactly one cycle and are never high together. `busy` is low in the cycle the pulse is seen.
- R10: A `start` while `busy` is high is ignored. The polled address is unchanged and no extra poll follows.
- R11: `abort` during polling returns the block to idle in the next cycle with no pulse and the stored toggle bit discarded. The next `start` begins with the first read of a new pair. `abort` has no effect while the reset write is pending.
- R12: `rd_req` and `wr_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin polling (accepted only when idle) |
| abort | input | 1 | Abandon polling without a result |
| sel_dq2 | input | 1 | 0: toggle bit is bit 6, 1: toggle bit is bit 2 |
| poll_addr | input | AW | Address to read status from, latched at start |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read acknowledge, `rd_data` valid with it |
| rd_data | input | 8 | Status byte returned by the device |
| wr_req | output | 1 | Write request for the reset command |
| wr_addr | output | AW | Write address |
| wr_data | output | 8 | Write data (reset command) |
| wr_ack | input | 1 | Write acknowledge |
| busy | output | 1 | Polling or reset write in progress |
| done | output | 1 | One-cycle pulse: operation finished |
| fail | output | 1 | One-cycle pulse: operation failed, reset written |

## Verification
The bench builds the block with `MAX_PAIRS` set to 3 and an 8-bit address. With that limit the watchdog expires after six status reads, so its forced failure and reset write can be reached in a short directed test. The small address width still allows a distinct polled address to be checked on every read and on the reset write. The default `MAX_PAIRS` would need thousands of reads before expiring.

// File: rtl/tpoll_pkg.sv
// Shared types for the toggle-bit polling controller.
// Assumes status bytes are 8 bits wide with fixed flag positions.
package tpoll_pkg;

    localparam int unsigned STAT_W     = 8;
    localparam int unsigned TOG_HI_POS = 6;
    localparam int unsigned TOG_LO_POS = 2;
    localparam int unsigned TMO_POS    = 5;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD_A   = 3'd1,
        ST_RD_B   = 3'd2,
        ST_CF_A   = 3'd3,
        ST_CF_B   = 3'd4,
        ST_WR_RST = 3'd5
    } tp_state_e;

endpackage

// File: rtl/tpoll_judge.sv
// Status byte decoder: picks the toggle bit under test, compares it with the
// bit stored from the previous read of the pair, and extracts the timeout flag.
// Assumes the caller only uses the outputs in the cycle the read is acknowledged.
module tpoll_judge
    import tpoll_pkg::*;
(
    input  logic              sel_lo,
    input  logic              held_bit,
    input  logic [STAT_W-1:0] stat,
    output logic              cur_bit,
    output logic              toggled,
    output logic              tmo_flag
);

    logic unused_stat;

    // Select the toggle bit and compare with the stored one.
    always_comb begin
        cur_bit  = sel_lo ? stat[TOG_LO_POS] : stat[TOG_HI_POS];
        toggled  = cur_bit ^ held_bit;
        tmo_flag = stat[TMO_POS];
    end

    assign unused_stat = ^{stat[7], stat[4:3], stat[1:0]};

endmodule

// File: rtl/tpoll_wdog.sv
// Counts toggling read pairs since the last clear. Reports expiry on the tick
// that reaches LIMIT. Assumes LIMIT >= 1 (the parent omits it when disabled).
module tpoll_wdog #(
    parameter int unsigned LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic expire
);

    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Pair counter: cleared at each new poll, advanced per toggling pair.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (tick)   cnt <= cnt + 1'b1;
    end

    assign expire = tick && (cnt == LAST);

endmodule

// File: rtl/toggle_poll_ctrl.sv
// Toggle-bit polling controller. After start, reads status in pairs, compares
// the selected toggle bit, confirms with one more pair once the timeout flag
// rises, and on failure writes the reset command before pulsing fail.
// Assumes a read/write responder that eventually acknowledges every request.
module toggle_poll_ctrl
    import tpoll_pkg::*;
#(
    parameter int unsigned AW        = 19,
    parameter int unsigned MAX_PAIRS = 1024,
    parameter logic [7:0]  RST_CMD   = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              sel_dq2,
    input  logic [AW-1:0]     poll_addr,
    output logic              rd_req,
    output logic [AW-1:0]     rd_addr,
    input  logic              rd_ack,
    input  logic [STAT_W-1:0] rd_data,
    output logic              wr_req,
    output logic [AW-1:0]     wr_addr,
    output logic [STAT_W-1:0] wr_data,
    input  logic              wr_ack,
    output logic              busy,
    output logic              done,
    output logic              fail
);

    tp_state_e     state;
    logic          held_bit;
    logic [AW-1:0] addr_q;
    logic          done_q, fail_q;
    logic          cur_bit, toggled, tmo_flag;
    logic          wd_expire;
    logic          accept;

    assign accept = (state == ST_IDLE) && start;

    tpoll_judge u_judge (
        .sel_lo   (sel_dq2),
        .held_bit (held_bit),
        .stat     (rd_data),
        .cur_bit  (cur_bit),
        .toggled  (toggled),
        .tmo_flag (tmo_flag)
    );

    generate
        if (MAX_PAIRS > 0) begin : g_wdog
            tpoll_wdog #(.LIMIT(MAX_PAIRS)) u_wdog (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr    (accept),
                .tick   ((state == ST_RD_B) && rd_ack && !abort && toggled && !tmo_flag),
                .expire (wd_expire)
            );
        end else begin : g_no_wdog
            assign wd_expire = 1'b0;
        end
    endgenerate

    // Sequencer: walks read pairs, confirmation pair and reset write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            held_bit <= 1'b0;
            addr_q   <= '0;
            done_q   <= 1'b0;
            fail_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        addr_q <= poll_addr;
                        state  <= ST_RD_A;
                    end
                end
                ST_RD_A, ST_CF_A: begin
                    if (abort) begin
                        state <= ST_IDLE;
                    end else if (rd_ack) begin
                        held_bit <= cur_bit;
                        state    <= (state == ST_RD_A) ? ST_RD_B : ST_CF_B;
                    end
                end
                ST_RD_B: begin
                    if (abort) begin
                        state <= ST_IDLE;
                    end else if (rd_ack) begin
                        if (!toggled) begin
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end else if (tmo_flag) begin
                            state <= ST_CF_A;
                        end else if (wd_expire) begin
                            state <= ST_WR_RST;
                        end else begin
                            state <= ST_RD_A;
                        end
                    end
                end
                ST_CF_B: begin
                    if (abort) begin
                        state <= ST_IDLE;
                    end else if (rd_ack) begin
                        if (!toggled) begin
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            state <= ST_WR_RST;
                        end
                    end
                end
                ST_WR_RST: begin
                    if (wr_ack) begin
                        fail_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Bus outputs decoded from the sequencer state.
    always_comb begin
        rd_req  = (state == ST_RD_A) || (state == ST_RD_B) ||
                  (state == ST_CF_A) || (state == ST_CF_B);
        wr_req  = (state == ST_WR_RST);
        rd_addr = addr_q;
        wr_addr = addr_q;
        wr_data = RST_CMD;
        busy    = (state != ST_IDLE);
        done    = done_q;
        fail    = fail_q;
    end

endmodule

// File: rtl/tpoll_chk.sv
// Protocol checker for toggle_poll_ctrl, attached by bind below.
// Observes ports only; assumes the synchronous active-low reset.
module tpoll_chk #(
    parameter int unsigned AW = 19
) (
    input logic          clk,
    input logic          rst_n,
    input logic          abort,
    input logic          rd_req,
    input logic [AW-1:0] rd_addr,
    input logic          rd_ack,
    input logic          wr_req,
    input logic          wr_ack,
    input logic          busy,
    input logic          done,
    input logic          fail
);

    // R9
    done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    fail_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> !fail);
    // R12
    bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));
    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack && !abort) |=> (rd_req && $stable(rd_addr)));
    // R6
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> wr_req);
    // R6
    fail_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> $past(wr_req && wr_ack));
    // R3
    done_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rd_req && rd_ack));
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_req && !wr_req));

endmodule

bind toggle_poll_ctrl tpoll_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .abort   (abort),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .rd_ack  (rd_ack),
    .wr_req  (wr_req),
    .wr_ack  (wr_ack),
    .busy    (busy),
    .done    (done),
    .fail    (fail)
);

// File: tb/tb_toggle_poll_ctrl.sv
// Directed bench for toggle_poll_ctrl: one task per scenario, each self-checking.
module tb_toggle_poll_ctrl;

    localparam int unsigned AW = 8;
    localparam int unsigned WD = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          abort = 1'b0;
    logic          sel_dq2 = 1'b0;
    logic [AW-1:0] poll_addr = '0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_ack = 1'b0;
    logic [7:0]    rd_data = 8'h00;
    logic          wr_req;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          wr_ack = 1'b0;
    logic          busy, done, fail;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    toggle_poll_ctrl #(.AW(AW), .MAX_PAIRS(WD)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .sel_dq2(sel_dq2), .poll_addr(poll_addr),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .busy(busy), .done(done), .fail(fail)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic kick(input logic [AW-1:0] a);
        poll_addr = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Answers one read after `dly` wait cycles; returns at the negedge after the ack edge.
    task automatic serve_read(input logic [7:0] d, input logic [AW-1:0] a, input int dly);
        while (!rd_req) @(negedge clk);
        check(rd_addr == a, "R2", "read address", 32'(rd_addr), 32'(a));
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            check(rd_req == 1'b1, "R2", "request held", 32'(rd_req), 1);
        end
        rd_data = d;
        rd_ack  = 1'b1;
        @(negedge clk);
        rd_ack  = 1'b0;
        rd_data = 8'h00;
    endtask

    task automatic expect_done(input string req);
        check(done == 1'b1, req, "done pulse", 32'(done), 1);
        check(fail == 1'b0, req, "no fail", 32'(fail), 0);
        check(busy == 1'b0, "R9", "idle at pulse", 32'(busy), 0);
        @(negedge clk);
        check(done == 1'b0, "R9", "done one cycle", 32'(done), 0);
    endtask

    task automatic serve_write_fail(input logic [AW-1:0] a, input string req);
        while (!wr_req) @(negedge clk);
        check(rd_req == 1'b0, "R12", "no read with write", 32'(rd_req), 0);
        check(wr_data == 8'hF0, "R6", "reset data", 32'(wr_data), 32'hF0);
        check(wr_addr == a, "R6", "reset address", 32'(wr_addr), 32'(a));
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check(wr_req == 1'b1 && fail == 1'b0, "R6", "write held, no fail yet",
                  32'({wr_req, fail}), 32'h2);
        end
        abort = 1'b1;             // R11: ignored during reset write
        @(negedge clk);
        abort = 1'b0;
        check(wr_req == 1'b1, "R11", "abort ignored in write", 32'(wr_req), 1);
        wr_ack = 1'b1;
        @(negedge clk);
        wr_ack = 1'b0;
        check(fail == 1'b1, req, "fail pulse", 32'(fail), 1);
        check(done == 1'b0, "R9", "no done with fail", 32'(done), 0);
        check(wr_req == 1'b0, "R6", "single write", 32'(wr_req), 0);
        @(negedge clk);
        check(fail == 1'b0, "R9", "fail one cycle", 32'(fail), 0);
    endtask

    task automatic t_reset();
        check({busy, rd_req, wr_req, done, fail} == 5'b0, "R1", "reset outputs",
              32'({busy, rd_req, wr_req, done, fail}), 0);
    endtask

    task automatic t_stable();
        sel_dq2 = 1'b0;
        kick(8'h3C);
        check(rd_req == 1'b1, "R2", "read after start", 32'(rd_req), 1);
        serve_read(8'h40, 8'h3C, 2);
        check(done == 1'b0 && rd_req == 1'b1, "R3", "second read pending",
              32'({done, rd_req}), 1);
        serve_read(8'h40, 8'h3C, 0);
        check(rd_req == 1'b0, "R3", "no read after done", 32'(rd_req), 0);
        expect_done("R3");
    endtask

    task automatic t_toggle_then_stable();
        kick(8'h11);
        serve_read(8'h00, 8'h11, 0);
        serve_read(8'h40, 8'h11, 1);
        check(done == 1'b0 && fail == 1'b0 && rd_req == 1'b1, "R4", "another pair",
              32'({done, fail, rd_req}), 1);
        serve_read(8'h00, 8'h11, 0);
        serve_read(8'h00, 8'h11, 0);
        expect_done("R4");
    endtask

    task automatic t_tmo_success();
        kick(8'h22);
        serve_read(8'h00, 8'h22, 0);
        serve_read(8'h60, 8'h22, 0);
        check(done == 1'b0 && rd_req == 1'b1, "R5", "confirm read issued",
              32'({done, rd_req}), 1);
        serve_read(8'h20, 8'h22, 0);
        serve_read(8'h20, 8'h22, 0);
        expect_done("R5");
    endtask

    task automatic t_tmo_fail();
        kick(8'h33);
        serve_read(8'h00, 8'h33, 0);
        serve_read(8'h60, 8'h33, 0);
        serve_read(8'h20, 8'h33, 0);
        serve_read(8'h60, 8'h33, 0);
        serve_write_fail(8'h33, "R6");
    endtask

    task automatic t_select();
        // bit 6 toggles, bit 2 steady: with bit 2 selected the result is done
        sel_dq2 = 1'b1;
        kick(8'h44);
        serve_read(8'h40, 8'h44, 0);
        serve_read(8'h00, 8'h44, 0);
        expect_done("R7");
        // bit 2 toggles, bit 6 steady: with bit 6 selected the result is done
        sel_dq2 = 1'b0;
        kick(8'h45);
        serve_read(8'h04, 8'h45, 0);
        serve_read(8'h00, 8'h45, 0);
        expect_done("R7");
        // bit 2 selected and toggling: not done after the pair
        sel_dq2 = 1'b1;
        kick(8'h46);
        serve_read(8'h00, 8'h46, 0);
        serve_read(8'h04, 8'h46, 0);
        check(done == 1'b0 && rd_req == 1'b1, "R7", "bit 2 toggle seen",
              32'({done, rd_req}), 1);
        serve_read(8'h04, 8'h46, 0);
        serve_read(8'h04, 8'h46, 0);
        expect_done("R7");
        sel_dq2 = 1'b0;
    endtask

    task automatic t_watchdog();
        kick(8'h55);
        for (int p = 0; p < int'(WD); p++) begin
            serve_read(8'h00, 8'h55, 0);
            serve_read(8'h40, 8'h55, 0);
            if (p < int'(WD) - 1)
                check(rd_req == 1'b1 && wr_req == 1'b0, "R8", "polling continues",
                      32'({rd_req, wr_req}), 32'h2);
        end
        check(wr_req == 1'b1, "R8", "watchdog forces reset write", 32'(wr_req), 1);
        serve_write_fail(8'h55, "R8");
    endtask

    task automatic t_busy_start();
        kick(8'h66);
        poll_addr = 8'h99;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        serve_read(8'h40, 8'h66, 0);
        serve_read(8'h40, 8'h66, 0);
        expect_done("R10");
        check(busy == 1'b0 && rd_req == 1'b0, "R10", "no extra poll",
              32'({busy, rd_req}), 0);
    endtask

    task automatic t_abort();
        kick(8'h77);
        serve_read(8'h00, 8'h77, 0);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check(busy == 1'b0 && rd_req == 1'b0 && done == 1'b0 && fail == 1'b0,
              "R11", "abort to idle", 32'({busy, rd_req, done, fail}), 0);
        repeat (2) @(negedge clk);
        check(done == 1'b0 && fail == 1'b0, "R11", "no pulse after abort",
              32'({done, fail}), 0);
        kick(8'h78);
        serve_read(8'h40, 8'h78, 0);
        serve_read(8'h40, 8'h78, 0);
        expect_done("R11");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stable();
        t_toggle_then_stable();
        t_tmo_success();
        t_tmo_fail();
        t_select();
        t_watchdog();
        t_busy_start();
        t_abort();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule